// File: doc/BRIEF.md
# Reservation Monitor for Linked Loads and Conditional Stores

This block keeps one reservation on behalf of a single processor port. A linked load opens a reservation on a 64-byte line and arms a countdown. Conditional stores to that line succeed only while the reservation is intact and the countdown has not expired. Two kinds of event break the reservation: an interrupt-taken pulse, and a snoop of the linked line. A snoop covers both another agent reading the line and an invalidation such as a DMA write; the line is found by comparing line addresses.

Conditional stores come in two flavours. A hold store parks its word in a private line buffer and keeps the reservation open. A release store merges its own word with every parked word and then closes the reservation. The merged words then leave on a valid/ready commit port toward memory. A clear request closes the reservation and throws away any parked words. A failing conditional store also throws them away, and it writes nothing.

The request port is valid/ready. `req_ready` is low while a committed line is still draining, so a request offered then simply waits. The commit port holds `cm_addr` and `cm_data` steady for as long as `cm_valid` is high and `cm_ready` is low. The result output is a plain one-cycle pulse.

Top module: `llsc_monitor`

## Requirements
- R1: Opcode encoding on `req_op` is 0 plain access, 1 linked load, 2 hold store, 3 release store, 4 clear. A linked load to a line that is not currently reserved reserves that line (address bits [AW-1:6]), reloads the countdown to CNT_PRESET and discards parked words.
- R2: A linked load to the line already reserved keeps the reservation as it stands. The countdown is not reloaded and parked words are kept.
- R3: The countdown drops by one every clock and stops at zero. A conditional store succeeds only if the countdown is nonzero in its acceptance cycle, so it succeeds when accepted at most CNT_PRESET cycles after its linked load.
- R4: A snoop (`snp_valid`) whose line address equals the reserved line breaks the reservation. A snoop to any other line has no effect.
- R5: An `irq_taken` pulse breaks the reservation.
- R6: A failing conditional store gives `rsp_ok`=0, puts nothing on the commit port, drops the reservation and discards parked words.
- R7: A conditional store to a line other than the reserved one fails, with the effects of R6.
- R8: A successful hold store gives `rsp_ok`=1. It parks its word at word index address bits [5:2], emits nothing, and keeps the reservation.
- R9: A successful release store gives `rsp_ok`=1. It then emits every parked word plus its own in ascending word index, at line base + 4×index. Its own word replaces a parked word at the same index. Afterwards the reservation is closed and no word remains parked.
- R10: A clear request drops the reservation and discards parked words. It gives no response.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and `cm_valid`=0. While `cm_valid`=1 and `cm_ready`=0, `cm_addr` and `cm_data` stay stable. `req_ready` is 0 while commit words remain.
- R12: The response to a conditional store arrives as `rsp_valid` exactly one cycle after acceptance. A break event in the acceptance cycle of a conditional store takes precedence, and the store fails.
- R13: A plain access is accepted and has no effect on the reservation. It gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 3 | Opcode (see R1) |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Conditional store result pulse |
| rsp_ok | output | 1 | 1 = store succeeded |
| snp_valid | input | 1 | Snoop or invalidation from another agent |
| snp_addr | input | AW | Snooped byte address |
| irq_taken | input | 1 | Interrupt taken pulse |
| cm_valid | output | 1 | Commit word valid |
| cm_ready | input | 1 | Memory accepts commit word |
| cm_addr | output | AW | Commit word address |
| cm_data | output | DW | Commit word data |

## Verification
A break event and the acceptance of a conditional store can land in the same cycle. The break can be a snoop of the reserved line or an interrupt pulse. The bench provokes this by raising `snp_valid` or `irq_taken` together with the `req_valid` of a hold or release store that is known to be accepted at once. The outcome is judged against a behavioural reference model that applies the break before the store. The store must return `rsp_ok`=0 and no commit word may appear. The commit port's back-pressure is exercised throughout by a recurring `cm_ready` stall pattern.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_LINK  = 3'd1,
    OP_HOLD  = 3'd2,
    OP_REL   = 3'd3,
    OP_CLEAR = 3'd4
  } llsc_op_e;
endpackage

// File: rtl/llsc_resv.sv
// Reservation state: link flag, reserved line tag and expiry countdown.
module llsc_resv #(
  parameter int TAG_W      = 26,
  parameter int CNT_PRESET = 12,
  localparam int CNT_W     = $clog2(CNT_PRESET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  logic             irq_i,
  input  logic             set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             drop_i,
  output logic             link_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             live_o
);
  logic             link_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             brk;

  assign brk    = link_q & ((snp_valid_i & (snp_tag_i == tag_q)) | irq_i);
  assign link_o = link_q & ~brk;
  assign tag_o  = tag_q;
  assign live_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (set_i) begin
        link_q <= 1'b1;
        tag_q  <= tag_i;
        cnt_q  <= CNT_W'(CNT_PRESET);
      end else begin
        if (drop_i || brk) link_q <= 1'b0;
        if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !set_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r3_cnt_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !set_i) |=> (cnt_q == '0));
  a_r5_irq_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !set_i) |=> !link_q);
  a_r4_snoop_breaks: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid_i && snp_tag_i == tag_q && !set_i) |=> !link_q);
endmodule

// File: rtl/llsc_pick.sv
// Lowest-index selector over a word mask.
module llsc_pick #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/llsc_holdbuf.sv
// Private line buffer: parks held words, then drains them in index order.
module llsc_holdbuf #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          rel_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  input  logic          cm_ready_i,
  output logic          drain_o,
  output logic [IW-1:0] out_idx_o,
  output logic [DW-1:0] out_data_o
);
  logic [WORDS-1:0] vmask_q;
  logic [WORDS-1:0] rest;
  logic [WORDS-1:0] we;
  logic [DW-1:0]    data_q [WORDS];
  logic             drain_q;
  logic [IW-1:0]    pick_idx;
  logic             unused_any;

  llsc_pick #(.N(WORDS)) u_pick (
    .mask_i (vmask_q),
    .idx_o  (pick_idx),
    .any_o  (unused_any)
  );

  for (genvar g = 0; g < WORDS; g++) begin : g_we
    assign we[g] = (wr_i | rel_i) && (idx_i == IW'(g));
  end

  always_comb begin
    rest           = vmask_q;
    rest[pick_idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < WORDS; k++) begin
      if (we[k]) data_q[k] <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmask_q <= '0;
      drain_q <= 1'b0;
    end else begin
      if (clr_i) vmask_q <= '0;
      else if (wr_i || rel_i) vmask_q[idx_i] <= 1'b1;
      else if (drain_q && cm_ready_i) vmask_q <= rest;
      if (rel_i) drain_q <= 1'b1;
      else if (drain_q && cm_ready_i && rest == '0) drain_q <= 1'b0;
    end
  end

  assign drain_o    = drain_q;
  assign out_idx_o  = pick_idx;
  assign out_data_o = data_q[pick_idx];

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && !cm_ready_i) |=> (drain_q && $stable(pick_idx) && $stable(out_data_o)));
  a_r9_drain_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && cm_ready_i && rest != '0) |=> (pick_idx > $past(pick_idx)));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int CNT_PRESET = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic          rsp_ok,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic          irq_taken,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data
);
  localparam int WB     = DW / 8;
  localparam int WORDS  = LINE_BYTES / WB;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BYTE_W = $clog2(WB);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int TAG_W  = AW - OFF_W;

  llsc_op_e         op;
  logic             acc, is_sc, same, sc_ok, keep;
  logic             link, live;
  logic [TAG_W-1:0] tag, req_tag, snp_tag;
  logic [IDX_W-1:0] req_idx, out_idx;
  logic             set, drop, clr, wr, rel;
  logic             unused_lo;

  assign op        = llsc_op_e'(req_op);
  assign req_tag   = req_addr[AW-1:OFF_W];
  assign req_idx   = req_addr[OFF_W-1:BYTE_W];
  assign snp_tag   = snp_addr[AW-1:OFF_W];
  assign unused_lo = ^{req_addr[BYTE_W-1:0], snp_addr[OFF_W-1:0]};

  assign acc   = req_valid & req_ready;
  assign is_sc = (op == OP_HOLD) || (op == OP_REL);
  assign same  = (req_tag == tag);
  assign keep  = link & same;
  assign sc_ok = link & live & same;

  assign set  = acc && (op == OP_LINK) && !keep;
  assign drop = acc && ((op == OP_CLEAR) || (op == OP_REL) || (is_sc && !sc_ok));
  assign clr  = acc && (((op == OP_LINK) && !keep) || (op == OP_CLEAR) || (is_sc && !sc_ok));
  assign wr   = acc && (op == OP_HOLD) && sc_ok;
  assign rel  = acc && (op == OP_REL) && sc_ok;

  llsc_resv #(.TAG_W(TAG_W), .CNT_PRESET(CNT_PRESET)) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_valid_i (snp_valid),
    .snp_tag_i   (snp_tag),
    .irq_i       (irq_taken),
    .set_i       (set),
    .tag_i       (req_tag),
    .drop_i      (drop),
    .link_o      (link),
    .tag_o       (tag),
    .live_o      (live)
  );

  llsc_holdbuf #(.WORDS(WORDS), .DW(DW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .wr_i       (wr),
    .rel_i      (rel),
    .idx_i      (req_idx),
    .data_i     (req_wdata),
    .cm_ready_i (cm_ready),
    .drain_o    (cm_valid),
    .out_idx_o  (out_idx),
    .out_data_o (cm_data)
  );

  assign cm_addr   = {tag, out_idx, {BYTE_W{1'b0}}};
  assign req_ready = ~cm_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= acc & is_sc;
      rsp_ok    <= acc & is_sc & sc_ok;
    end
  end

  a_r6_fail_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> !cm_valid);
  a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> !req_ready);
  a_r9_release_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ok && $past(req_op) == 3'd3) |-> cm_valid);
  a_r13_plain_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_PLAIN) |=> !rsp_valid);
  a_r8_hold_no_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == OP_HOLD) |=> !cm_valid);
endmodule

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
  localparam int PRESET = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ok;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        irq_taken = 1'b0;
  logic        cm_valid;
  logic        cm_ready = 1'b1;
  logic [31:0] cm_addr, cm_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  string ph = "R11";

  always #2 clk = ~clk;

  llsc_monitor #(.CNT_PRESET(PRESET)) u_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .irq_taken(irq_taken), .cm_valid(cm_valid),
    .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit          m_link;
  int          m_tag, m_cnt;
  bit          m_hv [16];
  logic [31:0] m_hd [16];
  logic [31:0] q_addr [$];
  logic [31:0] q_data [$];
  bit          m_rsp_v, m_rsp_ok;
  logic [31:0] mem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_link = 0; m_tag = 0; m_cnt = 0; m_rsp_v = 0; m_rsp_ok = 0;
      foreach (m_hv[i]) m_hv[i] = 0;
      q_addr.delete(); q_data.delete();
    end else begin
      bit ready, brk, link, ok;
      int cnt_now, t, ix;
      if (cm_valid && cm_ready) mem[int'(cm_addr)] = cm_data;
      ready = (q_addr.size() == 0);
      if (cm_ready && q_addr.size() > 0) begin
        void'(q_addr.pop_front()); void'(q_data.pop_front());
      end
      brk = m_link && ((snp_valid && int'(snp_addr >> 6) == m_tag) || irq_taken);
      link = m_link && !brk;
      cnt_now = m_cnt;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_rsp_v = 0; m_rsp_ok = 0;
      if (req_valid && ready) begin
        t = int'(req_addr >> 6);
        ix = int'((req_addr >> 2) & 32'hF);
        case (req_op)
          3'd1: if (!(link && t == m_tag)) begin
            link = 1; m_tag = t; m_cnt = PRESET;
            foreach (m_hv[i]) m_hv[i] = 0;
          end
          3'd2, 3'd3: begin
            ok = link && cnt_now > 0 && t == m_tag;
            m_rsp_v = 1; m_rsp_ok = ok;
            if (!ok) begin
              link = 0;
              foreach (m_hv[i]) m_hv[i] = 0;
            end else begin
              m_hv[ix] = 1; m_hd[ix] = req_wdata;
              if (req_op == 3'd3) begin
                for (int i = 0; i < 16; i++)
                  if (m_hv[i]) begin
                    q_addr.push_back(32'(m_tag << 6) | 32'(i << 2));
                    q_data.push_back(m_hd[i]);
                    m_hv[i] = 0;
                  end
                link = 0;
              end
            end
          end
          3'd4: begin
            link = 0;
            foreach (m_hv[i]) m_hv[i] = 0;
          end
          default: ;
        endcase
      end
      m_link = link;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = (q_addr.size() > 0);
      check(req_ready == !ev, {ph, " R11 req_ready"}, 32'(req_ready), 32'(!ev));
      check(cm_valid == ev, {ph, " R9 cm_valid"}, 32'(cm_valid), 32'(ev));
      if (ev && cm_valid) begin
        check(cm_addr == q_addr[0], {ph, " R9 cm_addr"}, cm_addr, q_addr[0]);
        check(cm_data == q_data[0], {ph, " R9 cm_data"}, cm_data, q_data[0]);
      end
      check(rsp_valid == m_rsp_v, {ph, " R12 rsp_valid"}, 32'(rsp_valid), 32'(m_rsp_v));
      if (m_rsp_v)
        check(rsp_ok == m_rsp_ok, {ph, " rsp_ok"}, 32'(rsp_ok), 32'(m_rsp_ok));
    end
  end

  // Memory-side back-pressure pattern
  always @(posedge clk) begin
    cyc++;
    #1 cm_ready = (cyc % 4 != 1);
  end

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                       input bit s = 0, input logic [31:0] sa = '0, input bit irq = 0);
    logic acc;
    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    snp_valid = s; snp_addr = sa; irq_taken = irq;
    forever begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
      snp_valid = 0; irq_taken = 0;
      if (acc) break;
    end
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic snoop(input logic [31:0] a);
    @(posedge clk); #1 snp_valid = 1; snp_addr = a;
    @(posedge clk); #1 snp_valid = 0;
  endtask

  task automatic irq_pulse();
    @(posedge clk); #1 irq_taken = 1;
    @(posedge clk); #1 irq_taken = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R11 reset req_ready", 32'(req_ready), 1);
    check(rsp_valid == 0, "R11 reset rsp_valid", 32'(rsp_valid), 0);
    check(cm_valid == 0, "R11 reset cm_valid", 32'(cm_valid), 0);

    ph = "R8";  // two held words then release
    issue(3'd1, 32'h1000, 0);
    issue(3'd2, 32'h1004, 32'hA1);
    issue(3'd2, 32'h100C, 32'hA3);
    ph = "R9";
    issue(3'd3, 32'h1000, 32'hA0);
    idle(8);

    ph = "R9";  // own word overrides parked word
    issue(3'd1, 32'h3000, 0);
    issue(3'd2, 32'h3008, 32'hB2);
    issue(3'd3, 32'h3008, 32'hC2);
    idle(6);

    ph = "R3";  // expiry then in-window success
    issue(3'd1, 32'h5000, 0);
    idle(PRESET + 2);
    issue(3'd3, 32'h5000, 32'hDEAD);
    issue(3'd1, 32'h4000, 0);
    idle(5);
    issue(3'd3, 32'h4010, 32'h44);
    idle(4);

    ph = "R4";  // snoop elsewhere harmless, snoop of line breaks
    issue(3'd1, 32'h6000, 0);
    snoop(32'h7000);
    issue(3'd3, 32'h6004, 32'h61);
    idle(4);
    issue(3'd1, 32'h5000, 0);
    snoop(32'h5020);
    issue(3'd3, 32'h5000, 32'hDEAD);

    ph = "R5";
    issue(3'd1, 32'h5000, 0);
    irq_pulse();
    issue(3'd2, 32'h5000, 32'hDEAD);

    ph = "R7";  // wrong line fails, then original line also fails (R6)
    issue(3'd1, 32'h5000, 0);
    issue(3'd2, 32'h5004, 32'hDEAD);
    issue(3'd2, 32'h9004, 32'hDEAD);
    ph = "R6";
    issue(3'd3, 32'h5008, 32'hDEAD);

    ph = "R2";  // repeated linked load keeps parked word
    issue(3'd1, 32'h2000, 0);
    issue(3'd2, 32'h2014, 32'h25);
    issue(3'd1, 32'h2000, 0);
    issue(3'd3, 32'h2018, 32'h26);
    idle(6);

    ph = "R1";  // link to a new line drops the old one
    issue(3'd1, 32'h5000, 0);
    issue(3'd1, 32'h8000, 0);
    issue(3'd3, 32'h5000, 32'hDEAD);

    ph = "R10";
    issue(3'd1, 32'h5000, 0);
    issue(3'd2, 32'h500C, 32'hDEAD);
    issue(3'd4, 32'h5000, 0);
    issue(3'd3, 32'h5000, 32'hDEAD);

    ph = "R12";  // break in the same cycle as the conditional store
    issue(3'd1, 32'h5000, 0);
    issue(3'd3, 32'h5000, 32'hDEAD, 1, 32'h5004, 0);
    issue(3'd1, 32'h5000, 0);
    issue(3'd2, 32'h5000, 32'hDEAD, 0, 32'h0, 1);

    ph = "R13";  // plain access inside a sequence
    issue(3'd1, 32'hA000, 0);
    issue(3'd0, 32'hA000, 32'h0);
    issue(3'd3, 32'hA01C, 32'hA7);
    idle(6);

    @(negedge clk);
    check(mem.exists(32'h1000) && mem[32'h1000] == 32'hA0, "R9 mem 1000", mem.exists(32'h1000) ? mem[32'h1000] : 'x, 32'hA0);
    check(mem.exists(32'h1004) && mem[32'h1004] == 32'hA1, "R8 mem 1004", mem.exists(32'h1004) ? mem[32'h1004] : 'x, 32'hA1);
    check(mem.exists(32'h100C) && mem[32'h100C] == 32'hA3, "R8 mem 100C", mem.exists(32'h100C) ? mem[32'h100C] : 'x, 32'hA3);
    check(!mem.exists(32'h1008), "R9 mem 1008 untouched", 32'(mem.exists(32'h1008)), 0);
    check(mem.exists(32'h3008) && mem[32'h3008] == 32'hC2, "R9 override 3008", mem.exists(32'h3008) ? mem[32'h3008] : 'x, 32'hC2);
    check(mem.exists(32'h4010) && mem[32'h4010] == 32'h44, "R3 in window", mem.exists(32'h4010) ? mem[32'h4010] : 'x, 32'h44);
    check(mem.exists(32'h6004) && mem[32'h6004] == 32'h61, "R4 other snoop", mem.exists(32'h6004) ? mem[32'h6004] : 'x, 32'h61);
    check(mem.exists(32'h2014) && mem[32'h2014] == 32'h25, "R2 kept word", mem.exists(32'h2014) ? mem[32'h2014] : 'x, 32'h25);
    check(mem.exists(32'hA01C) && mem[32'hA01C] == 32'hA7, "R13 plain", mem.exists(32'hA01C) ? mem[32'hA01C] : 'x, 32'hA7);
    for (int i = 0; i < 16; i++)
      check(!mem.exists(32'h5000 + 4 * i), "R6 failed line untouched", 32'(mem.exists(32'h5000 + 4 * i)), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule